// File: doc/BRIEF.md
# Serial Flash Configuration Stream Loader

This block is the serial-flash side of a configuration sequencer. A single start pulse makes it open a read transaction on a serial NOR flash. It first sends a read opcode picked by a 3-bit variant code, then a 24-bit start address of zero, then any dummy cycles, and from then on it keeps clocking to pull the stored image in bit by bit. The serial clock is the system clock divided down by a parameter.

The incoming bytes go to a stream parser. The parser skips any bytes ahead of a 32-bit synchronisation pattern and reads a 32-bit payload length. It then hands exactly that many payload bytes to the fabric on a byte bus with a one-cycle valid strobe, folding each payload byte into a CRC-32. A 32-bit trailer is compared against that CRC. Once the trailer is consumed, or once the sync search has run too long, chip select is released and the serial clock stops. The block then reports either success or an error with a fault code, and holds that result until the next start.

Top module: `cfg_flash_loader`

## Requirements
- R1: Out of reset, spi_cs_n is 1, spi_sck is 0, data_valid is 0, done is 0, error is 0 and fault_code is 0.
- R2: A start with variant 3'b111 sends opcode 0x0B, then address 0x000000, then one dummy byte. The first image bit is sampled on the 41st rising clock edge of the transaction.
- R3: A start with variant 3'b101 sends opcode 0x03, then address 0x000000, with no dummy byte. The first image bit is sampled on the 33rd rising edge.
- R4: A start with any other variant code sets error with fault_code 2'd1 on the next cycle. In that case spi_cs_n never goes low.
- R5: The serial link runs in SPI mode 0, most significant bit first. spi_sck idles low, spi_mosi only changes while spi_sck is low, and spi_miso is sampled on the rising edge.
- R6: Image bytes before the first byte-aligned occurrence of AA 99 55 66 are discarded and produce no data_valid.
- R7: The four bytes after the sync pattern form the payload length L, most significant byte first. Exactly L payload bytes then appear in order on data_byte, each with a one-cycle data_valid.
- R8: The four bytes after the payload form a trailer, most significant byte first. It is compared with the CRC-32 of the payload (reflected polynomial 0xEDB88320, initial value all ones, final inversion). A match gives done=1 with fault_code 0. A mismatch gives error=1 with fault_code 2'd3.
- R9: If the sync pattern is not complete within sync_limit image bytes, error=1 is raised with fault_code 2'd2 and no data_valid is produced. A pattern ending exactly on byte sync_limit is accepted.
- R10: spi_cs_n stays low from the first opcode bit to the last trailer bit. After the result is reported, spi_cs_n is 1 and spi_sck makes no further edges.
- R11: A payload length of zero skips straight to the trailer. The expected trailer is then 0x00000000.
- R12: done and error are never both 1. Each holds its value until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to load; ignored while a load is running |
| variant | input | 3 | Read-variant code, captured at start |
| sync_limit | input | TMO_W | Image bytes allowed for the sync search |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock to flash |
| spi_mosi | output | 1 | Command/address data to flash |
| spi_miso | input | 1 | Image data from flash |
| data_byte | output | 8 | Payload byte |
| data_valid | output | 1 | data_byte is valid this cycle |
| done | output | 1 | Load finished with matching CRC |
| error | output | 1 | Load failed |
| fault_code | output | 2 | 0 none, 1 bad variant, 2 sync timeout, 3 CRC mismatch |

## Verification
The properties assume three things about the inputs. First, the flash drives spi_miso only on falling serial-clock edges. Second, variant and sync_limit stay stable from the start pulse until the result. Third, start is a single-cycle pulse. The bench enforces all three: its flash model updates MISO only on falling clock edges while selected, and it changes variant and sync_limit only between loads. Those loads are sweeps over both read variants, payload lengths from zero upward, several preamble lengths, a corrupted trailer, both sides of the sync timeout boundary, and every unsupported variant code.

// File: rtl/cfg_flash_pkg.sv
package cfg_flash_pkg;

  localparam logic [31:0] SYNC_WORD = 32'hAA99_5566;
  localparam logic [31:0] CRC_POLY  = 32'hEDB8_8320;
  localparam int          HDR_W     = 32;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_VARIANT = 2'd1,
    FLT_TIMEOUT = 2'd2,
    FLT_CRC     = 2'd3
  } fault_t;

  typedef enum logic [1:0] {
    TS_IDLE,
    TS_CMD,
    TS_STREAM
  } top_state_t;

  typedef enum logic [2:0] {
    PS_HUNT,
    PS_LEN,
    PS_PAY,
    PS_TRL,
    PS_END
  } parse_state_t;

  typedef struct packed {
    logic       ok;
    logic [7:0] opcode;
    logic [2:0] cmd_bytes;
  } rd_mode_t;

  function automatic rd_mode_t decode_variant(input logic [2:0] v);
    rd_mode_t m;
    m = '{ok: 1'b0, opcode: 8'h00, cmd_bytes: 3'd0};
    case (v)
      3'b111:  m = '{ok: 1'b1, opcode: 8'h0B, cmd_bytes: 3'd5};
      3'b101:  m = '{ok: 1'b1, opcode: 8'h03, cmd_bytes: 3'd4};
      default: m = '{ok: 1'b0, opcode: 8'h00, cmd_bytes: 3'd0};
    endcase
    return m;
  endfunction

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/cfg_spi_byte_engine.sv
module cfg_spi_byte_engine #(
  parameter int CLK_DIV = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       byte_done,
  output logic [7:0] rx_byte
);

  localparam int CW = $clog2(CLK_DIV) + 1;
  localparam logic [CW-1:0] HALF_LAST = CW'(CLK_DIV - 1);

  logic          active;
  logic [CW-1:0] div_cnt;
  logic [2:0]    bit_idx;
  logic [7:0]    tx_sh;
  logic [7:0]    rx_sh;

  always_ff @(posedge clk) begin
    byte_done <= 1'b0;
    if (rst) begin
      active  <= 1'b0;
      div_cnt <= '0;
      bit_idx <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      rx_byte <= '0;
      sck     <= 1'b0;
      mosi    <= 1'b0;
    end else if (!active) begin
      if (go) begin
        active  <= 1'b1;
        tx_sh   <= tx_byte;
        mosi    <= tx_byte[7];
        bit_idx <= '0;
        div_cnt <= '0;
        sck     <= 1'b0;
      end
    end else if (div_cnt == HALF_LAST) begin
      div_cnt <= '0;
      if (!sck) begin
        // rising edge: capture flash data
        sck   <= 1'b1;
        rx_sh <= {rx_sh[6:0], miso};
      end else begin
        // falling edge: present next command bit or finish
        sck <= 1'b0;
        if (bit_idx == 3'd7) begin
          active    <= 1'b0;
          byte_done <= 1'b1;
          rx_byte   <= rx_sh;
        end else begin
          bit_idx <= bit_idx + 3'd1;
          tx_sh   <= {tx_sh[6:0], 1'b0};
          mosi    <= tx_sh[6];
        end
      end
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/cfg_crc32.sv
module cfg_crc32 (
  input  logic        clk,
  input  logic        rst,
  input  logic        init,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc
);
  import cfg_flash_pkg::*;

  always_ff @(posedge clk) begin
    if (rst || init) begin
      crc <= 32'hFFFF_FFFF;
    end else if (en) begin
      crc <= crc_step(crc, din);
    end
  end

endmodule

// File: rtl/cfg_stream_parser.sv
module cfg_stream_parser #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  input  logic [TMO_W-1:0] limit,
  output logic             out_valid,
  output logic [7:0]       out_byte,
  output logic             fin,
  output logic             ok,
  output logic             timed_out
);
  import cfg_flash_pkg::*;

  parse_state_t     ps;
  logic [31:0]      win;
  logic [31:0]      len_acc;
  logic [31:0]      remain;
  logic [31:0]      trl;
  logic [TMO_W-1:0] seen;
  logic [1:0]       hdr_idx;
  logic [31:0]      crc_state;

  logic [31:0]      win_n;
  logic [31:0]      len_n;
  logic [31:0]      trl_n;
  logic [TMO_W-1:0] seen_n;
  logic             crc_en;

  assign win_n  = {win[23:0], in_byte};
  assign len_n  = {len_acc[23:0], in_byte};
  assign trl_n  = {trl[23:0], in_byte};
  assign seen_n = seen + 1'b1;
  assign crc_en = in_valid && (ps == PS_PAY);

  cfg_crc32 u_crc (
    .clk  (clk),
    .rst  (rst),
    .init (clr),
    .en   (crc_en),
    .din  (in_byte),
    .crc  (crc_state)
  );

  always_ff @(posedge clk) begin
    out_valid <= 1'b0;
    if (rst || clr) begin
      ps        <= PS_HUNT;
      win       <= '0;
      len_acc   <= '0;
      remain    <= '0;
      trl       <= '0;
      seen      <= '0;
      hdr_idx   <= '0;
      out_byte  <= '0;
      fin       <= 1'b0;
      ok        <= 1'b0;
      timed_out <= 1'b0;
    end else if (in_valid) begin
      case (ps)
        PS_HUNT: begin
          win  <= win_n;
          seen <= seen_n;
          if (win_n == SYNC_WORD) begin
            ps      <= PS_LEN;
            hdr_idx <= '0;
          end else if (seen_n >= limit) begin
            ps        <= PS_END;
            fin       <= 1'b1;
            timed_out <= 1'b1;
          end
        end
        PS_LEN: begin
          len_acc <= len_n;
          hdr_idx <= hdr_idx + 2'd1;
          if (hdr_idx == 2'd3) begin
            if (len_n == '0) begin
              ps <= PS_TRL;
            end else begin
              ps     <= PS_PAY;
              remain <= len_n;
            end
          end
        end
        PS_PAY: begin
          out_valid <= 1'b1;
          out_byte  <= in_byte;
          remain    <= remain - 1'b1;
          if (remain == 32'd1) ps <= PS_TRL;
        end
        PS_TRL: begin
          trl     <= trl_n;
          hdr_idx <= hdr_idx + 2'd1;
          if (hdr_idx == 2'd3) begin
            ps  <= PS_END;
            fin <= 1'b1;
            ok  <= (trl_n == ~crc_state);
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/cfg_flash_loader.sv
module cfg_flash_loader #(
  parameter int CLK_DIV = 2,
  parameter int TMO_W   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [2:0]       variant,
  input  logic [TMO_W-1:0] sync_limit,
  output logic             spi_cs_n,
  output logic             spi_sck,
  output logic             spi_mosi,
  input  logic             spi_miso,
  output logic [7:0]       data_byte,
  output logic             data_valid,
  output logic             done,
  output logic             error,
  output logic [1:0]       fault_code
);
  import cfg_flash_pkg::*;

  top_state_t st;
  rd_mode_t   mode_n;
  logic       go_q;
  logic [7:0] tx_q;
  logic [2:0] cmd_idx;
  logic [2:0] cmd_total;
  logic       pend;
  logic       busy;

  logic       eng_done;
  logic [7:0] eng_rx;
  logic       p_clr;
  logic       p_valid;
  logic       p_fin;
  logic       p_ok;
  logic       p_tmo;

  assign mode_n  = decode_variant(variant);
  assign busy    = (st != TS_IDLE);
  assign p_clr   = (st == TS_IDLE) && start;
  assign p_valid = eng_done && (st == TS_STREAM);

  cfg_spi_byte_engine #(.CLK_DIV(CLK_DIV)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .go        (go_q),
    .tx_byte   (tx_q),
    .miso      (spi_miso),
    .sck       (spi_sck),
    .mosi      (spi_mosi),
    .byte_done (eng_done),
    .rx_byte   (eng_rx)
  );

  cfg_stream_parser #(.TMO_W(TMO_W)) u_parse (
    .clk       (clk),
    .rst       (rst),
    .clr       (p_clr),
    .in_valid  (p_valid),
    .in_byte   (eng_rx),
    .limit     (sync_limit),
    .out_valid (data_valid),
    .out_byte  (data_byte),
    .fin       (p_fin),
    .ok        (p_ok),
    .timed_out (p_tmo)
  );

  always_ff @(posedge clk) begin
    go_q <= 1'b0;
    if (rst) begin
      st         <= TS_IDLE;
      tx_q       <= '0;
      cmd_idx    <= '0;
      cmd_total  <= '0;
      pend       <= 1'b0;
      spi_cs_n   <= 1'b1;
      done       <= 1'b0;
      error      <= 1'b0;
      fault_code <= FLT_NONE;
    end else begin
      // next-byte decision is taken one cycle after a byte completes,
      // once the parser has absorbed it
      pend <= eng_done;
      case (st)
        TS_IDLE: begin
          if (start) begin
            done       <= 1'b0;
            error      <= 1'b0;
            fault_code <= FLT_NONE;
            if (mode_n.ok) begin
              st        <= TS_CMD;
              spi_cs_n  <= 1'b0;
              go_q      <= 1'b1;
              tx_q      <= mode_n.opcode;
              cmd_idx   <= 3'd1;
              cmd_total <= mode_n.cmd_bytes;
            end else begin
              error      <= 1'b1;
              fault_code <= FLT_VARIANT;
            end
          end
        end
        TS_CMD: begin
          if (pend) begin
            go_q <= 1'b1;
            tx_q <= 8'h00;      // address and dummy bytes are all zero
            if (cmd_idx == cmd_total) begin
              st <= TS_STREAM;
            end else begin
              cmd_idx <= cmd_idx + 3'd1;
            end
          end
        end
        TS_STREAM: begin
          if (pend) begin
            if (p_fin) begin
              st         <= TS_IDLE;
              spi_cs_n   <= 1'b1;
              done       <= p_ok;
              error      <= !p_ok;
              fault_code <= p_ok ? FLT_NONE : (p_tmo ? FLT_TIMEOUT : FLT_CRC);
            end else begin
              go_q <= 1'b1;
              tx_q <= 8'h00;
            end
          end
        end
        default: st <= TS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfg_flash_loader_chk.sv
module cfg_flash_loader_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic [2:0] variant,
  input logic       busy,
  input logic       spi_cs_n,
  input logic       spi_sck,
  input logic       spi_mosi,
  input logic       data_valid,
  input logic       done,
  input logic       error,
  input logic [1:0] fault_code
);

  a_r5_mosi_hold: assert property (@(posedge clk) disable iff (rst)
    spi_sck |-> $stable(spi_mosi));

  a_r10_sck_idle: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sck);

  a_r10_cs_only_busy: assert property (@(posedge clk) disable iff (rst)
    !busy |-> spi_cs_n);

  a_r12_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(done && error));

  a_r12_done_hold: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  a_r12_error_hold: assert property (@(posedge clk) disable iff (rst)
    (error && !start) |=> error);

  a_r4_bad_variant: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !(variant == 3'b111 || variant == 3'b101))
      |=> (error && fault_code == 2'd1 && spi_cs_n));

  a_r7_valid_in_txn: assert property (@(posedge clk) disable iff (rst)
    data_valid |-> !spi_cs_n);

endmodule

bind cfg_flash_loader cfg_flash_loader_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .variant    (variant),
  .busy       (busy),
  .spi_cs_n   (spi_cs_n),
  .spi_sck    (spi_sck),
  .spi_mosi   (spi_mosi),
  .data_valid (data_valid),
  .done       (done),
  .error      (error),
  .fault_code (fault_code)
);

// File: tb/cfg_flash_loader_test.sv
module cfg_flash_loader_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  variant = 3'b000;
  logic [15:0] sync_limit = 16'd64;
  logic        spi_cs_n, spi_sck, spi_mosi;
  logic        spi_miso = 1'b0;
  logic [7:0]  data_byte;
  logic        data_valid, done, error;
  logic [1:0]  fault_code;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  cfg_flash_loader #(.CLK_DIV(2), .TMO_W(16)) uut (
    .clk(clk), .rst(rst), .start(start), .variant(variant),
    .sync_limit(sync_limit), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .data_byte(data_byte),
    .data_valid(data_valid), .done(done), .error(error),
    .fault_code(fault_code)
  );

  // ---------------- flash model ----------------
  logic [7:0]  img [0:127];
  int          img_len = 0;
  int          pay_off = 0;
  int          pay_len = 0;
  int          nbits = 0;
  logic [31:0] cmd_sh = '0;
  logic [31:0] last_cmd = '0;
  int          cs_falls = 0;
  int          sck_rises = 0;
  int          mosi_viol = 0;

  always @(posedge spi_sck or posedge spi_cs_n) begin
    if (spi_cs_n) begin
      nbits  = 0;
      cmd_sh = '0;
    end else begin
      if (nbits < 32) cmd_sh = {cmd_sh[30:0], spi_mosi};
      nbits = nbits + 1;
      if (nbits == 32) last_cmd = cmd_sh;
    end
  end

  always @(negedge spi_sck) begin
    if (!spi_cs_n) begin
      int hdr;
      int idx;
      hdr = (cmd_sh[31:24] == 8'h0B) ? 40 : 32;
      if (nbits >= hdr) begin
        idx = nbits - hdr;
        spi_miso <= (idx / 8 < img_len) ? img[idx / 8][7 - idx % 8] : 1'b1;
      end
    end
  end

  always @(negedge spi_cs_n) cs_falls = cs_falls + 1;
  always @(posedge spi_sck)  sck_rises = sck_rises + 1;

  logic prev_sck = 1'b0, prev_mosi = 1'b0;
  logic [7:0] rx_buf [0:1023];
  int rx_n = 0;
  always @(negedge clk) begin
    if (prev_sck && spi_sck && (prev_mosi !== spi_mosi)) mosi_viol = mosi_viol + 1;
    prev_sck  = spi_sck;
    prev_mosi = spi_mosi;
    if (data_valid && rx_n < 1024) begin
      rx_buf[rx_n] = data_byte;
      rx_n = rx_n + 1;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input int off, input int n);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int k = 0; k < n; k++) begin
      c = c ^ {24'h0, img[off + k]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic build(input int n_pre, input int plen, input int seed, input bit bad);
    int i;
    logic [31:0] c;
    i = 0;
    for (int k = 0; k < n_pre; k++) begin img[i] = 8'(8'h10 + k); i++; end
    img[i] = 8'hAA; img[i+1] = 8'h99; img[i+2] = 8'h55; img[i+3] = 8'h66; i += 4;
    img[i] = 8'(plen >> 24); img[i+1] = 8'(plen >> 16);
    img[i+2] = 8'(plen >> 8); img[i+3] = 8'(plen); i += 4;
    pay_off = i;
    pay_len = plen;
    for (int k = 0; k < plen; k++) begin img[i] = 8'(seed * 7 + k * 13 + 1); i++; end
    c = ref_crc(pay_off, plen);
    if (bad) c = c ^ 32'h1;
    img[i] = c[31:24]; img[i+1] = c[23:16]; img[i+2] = c[15:8]; img[i+3] = c[7:0]; i += 4;
    img_len = i;
  endtask

  int rx_base, falls_base;

  task automatic run(input logic [2:0] v, input int lim);
    int w;
    rx_base    = rx_n;
    falls_base = cs_falls;
    @(negedge clk);
    variant    = v;
    sync_limit = 16'(lim);
    start      = 1'b1;
    @(negedge clk);
    start = 1'b0;
    w = 0;
    while (!(done || error) && w < 30000) begin
      @(negedge clk);
      w++;
    end
    chk(w < 30000, "R10 load finishes", w, 0);
  endtask

  task automatic expect_good(input logic [2:0] v, input string tag);
    int rises;
    chk(done == 1'b1 && error == 1'b0, {tag, " R8 done"}, {done, error}, 2'b10);
    chk(fault_code == 2'd0, {tag, " R8 fault none"}, fault_code, 0);
    chk(last_cmd[31:24] == ((v == 3'b111) ? 8'h0B : 8'h03),
        (v == 3'b111) ? {tag, " R2 opcode"} : {tag, " R3 opcode"},
        last_cmd[31:24], (v == 3'b111) ? 8'h0B : 8'h03);
    chk(last_cmd[23:0] == 24'h0, {tag, " R2 R3 address"}, last_cmd[23:0], 0);
    chk(rx_n - rx_base == pay_len, {tag, " R7 byte count"}, rx_n - rx_base, pay_len);
    for (int k = 0; k < pay_len && k < rx_n - rx_base; k++)
      chk(rx_buf[rx_base + k] == img[pay_off + k], {tag, " R7 payload byte"},
          rx_buf[rx_base + k], img[pay_off + k]);
    chk(cs_falls - falls_base == 1, {tag, " R10 single select"}, cs_falls - falls_base, 1);
    rises = sck_rises;
    repeat (40) @(negedge clk);
    chk(spi_cs_n == 1'b1 && sck_rises == rises, {tag, " R10 idle after load"},
        sck_rises - rises, 0);
    chk(done == 1'b1, {tag, " R12 done held"}, done, 1);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(spi_cs_n == 1 && spi_sck == 0 && data_valid == 0, "R1 reset pins",
        {spi_cs_n, spi_sck, data_valid}, 3'b100);
    chk(done == 0 && error == 0 && fault_code == 0, "R1 reset status",
        {done, error, fault_code}, 0);

    // R2/R3/R6/R7/R8/R11: sweep variants, payload lengths and preambles
    for (int pl = 0; pl < 7; pl++) begin
      build(pl % 3, pl, pl + 3, 1'b0);
      run(3'b111, 64);
      expect_good(3'b111, "fast");
      build((pl + 1) % 3, pl, pl + 11, 1'b0);
      run(3'b101, 64);
      expect_good(3'b101, "read");
    end

    // R6: longer preamble with a partial sync lookalike
    build(5, 9, 42, 1'b0);
    img[2] = 8'hAA; img[3] = 8'h99;
    run(3'b111, 64);
    expect_good(3'b111, "R6 preamble");

    // R8: corrupted trailer
    build(1, 6, 5, 1'b1);
    run(3'b101, 64);
    chk(error == 1 && done == 0 && fault_code == 2'd3, "R8 crc mismatch",
        {done, error, fault_code}, 4'b0111);
    chk(rx_n - rx_base == 6, "R8 payload still delivered", rx_n - rx_base, 6);
    chk(spi_cs_n == 1, "R10 released after error", spi_cs_n, 1);
    repeat (20) @(negedge clk);
    chk(error == 1 && done == 0, "R12 error held", {done, error}, 2'b01);

    // R9: sync ending exactly on the limit is accepted
    build(2, 3, 9, 1'b0);
    run(3'b111, 6);
    chk(done == 1 && fault_code == 0, "R9 sync at limit accepted", {done, fault_code}, 4);

    // R9: one byte late times out
    build(3, 3, 9, 1'b0);
    run(3'b111, 6);
    chk(error == 1 && fault_code == 2'd2, "R9 sync timeout", {error, fault_code}, 3'b110);
    chk(rx_n - rx_base == 0, "R9 no data on timeout", rx_n - rx_base, 0);
    chk(spi_cs_n == 1, "R9 R10 released after timeout", spi_cs_n, 1);

    // R4: every unsupported variant
    for (int v = 0; v < 8; v++) begin
      if (v != 5 && v != 7) begin
        run(3'(v), 64);
        chk(error == 1 && fault_code == 2'd1 && done == 0, "R4 bad variant",
            {done, error, fault_code}, 4'b0101);
        chk(cs_falls - falls_base == 0, "R4 no select", cs_falls - falls_base, 0);
      end
    end

    // R12: a good load after an error clears the error
    build(0, 4, 77, 1'b0);
    run(3'b101, 64);
    chk(done == 1 && error == 0, "R12 cleared by new start", {done, error}, 2'b10);

    chk(mosi_viol == 0, "R5 mosi stable while sck high", mosi_viol, 0);

    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end

endmodule